// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flag and Alarm Controller

This block sits beside the time-keeping counters of a real-time clock. It gathers three interrupt sources: a periodic tick from the divider, a once-per-second update completion, and an alarm. The alarm fires when the freshly updated hours, minutes and seconds agree with three alarm bytes. An alarm byte whose two top bits are both 1 acts as a wildcard and matches any value. Each source has a sticky flag and an enable bit. The active-low interrupt line is asserted whenever some flag is set together with its enable.

Software sees two bytes. The status byte holds the three flags and their combined request. Reading it clears the flags. A flag event that arrives in the same cycle as the read is not lost: it is parked in a pending register and merged into the flags one cycle later. A two-state machine tracks this: `ST_RUN` is normal operation, and `ST_DRAIN` is the cycle after a read, in which parked events are merged. The machine moves from `ST_RUN` to `ST_DRAIN` on any read. It leaves `ST_DRAIN` for `ST_RUN` on a cycle without a read, and stays in `ST_DRAIN` if another read arrives. The control byte holds the enables, a freeze bit, a square-wave enable and three plain storage bits.

Bus decoding, the counters and the divider are outside the block. It receives one-cycle strobes for a status read and a control write.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: The status byte carries the combined request in bit 7, the periodic flag in bit 6, the alarm flag in bit 5 and the update flag in bit 4. Bits 3 to 0 always read 0.
- R2: The control byte holds the freeze bit in bit 7, the periodic enable in bit 6, the alarm enable in bit 5, the update enable in bit 4 and the square-wave enable in bit 3. Bits 2 to 0 are plain storage. A write strobe loads the byte at the next clock edge.
- R3: `irq_n` is low exactly when (periodic flag and its enable), (alarm flag and its enable) or (update flag and its enable) holds. Status bit 7 equals the inverse of `irq_n`. Setting an enable while its flag is already 1 asserts `irq_n` right after the write edge.
- R4: The periodic tick sets the periodic flag at the next edge whatever the enables are. A set flag stays set until it is read or reset.
- R5: While `stat_rd` is high for its single cycle, `status` shows the current flags. At the following edge every flag and the request bit clear.
- R6: A periodic, alarm or update event in the same cycle as a read is held. It appears in the status byte after the second edge following the read.
- R7: The alarm flag is set only on an update pulse, and only when each alarm byte either equals its time byte or has both top bits at 1 (C0 to FF). Byte lanes are seconds in bits 7:0, minutes in 15:8 and hours in 23:16. A value with only bit 7 set is not a wildcard.
- R8: The update pulse sets the update flag only while the freeze bit is 0.
- R9: A control write with bit 7 at 1 leaves the update enable at 0, whatever is written to bit 4.
- R10: While `rst_n` is low, all flags, the pending events and the periodic, alarm, update and square-wave enables are 0, and `irq_n` is high. The freeze bit and control bits 2 to 0 keep their value and still accept writes during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset with the R10 effects |
| per_tick | input | 1 | One-cycle pulse from the selected divider tap |
| upd_done | input | 1 | One-cycle pulse when a time update completes |
| time_bytes | input | 24 | Updated hours, minutes, seconds (hours high) |
| alarm_bytes | input | 24 | Alarm hours, minutes, seconds (hours high) |
| stat_rd | input | 1 | One-cycle status read strobe |
| ctrl_we | input | 1 | One-cycle control write strobe |
| ctrl_wdata | input | 8 | Control write data |
| status | output | 8 | Status byte |
| ctrl | output | 8 | Control byte |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
On every cycle, the assertions check three things: the relation between `irq_n`, the status flags and the control enables; that a read always leaves an empty status byte; and that flags are sticky. They also check that a tick sets its flag, that a freeze write clears the update enable, that parked events reappear, and the reset state of the outputs. Only the bench scenarios can show the alarm comparison. That covers exact matches, mismatches, true wildcards and the single-top-bit non-wildcard. Only the bench can also show that the freeze bit suppresses the update flag and that the freeze bit survives reset.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
    localparam int BYTE_W     = 8;
    localparam int NUM_FIELDS = 3;

    localparam int CB_FREEZE = 7;
    localparam int CB_PER_EN = 6;
    localparam int CB_ALM_EN = 5;
    localparam int CB_UPD_EN = 4;
    localparam int CB_SQW_EN = 3;

    localparam int SB_REQ = 7;
    localparam int SB_PER = 6;
    localparam int SB_ALM = 5;
    localparam int SB_UPD = 4;

    typedef enum logic {ST_RUN, ST_DRAIN} flag_state_e;

    typedef struct packed {
        logic per;
        logic alm;
        logic upd;
    } flag_vec_t;
endpackage

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
    parameter int BYTE_W     = 8,
    parameter int NUM_FIELDS = 3,
    localparam int BUS_W     = BYTE_W * NUM_FIELDS
) (
    input  logic [BUS_W-1:0] cur_bytes,
    input  logic [BUS_W-1:0] alm_bytes,
    output logic             hit
);
    logic [NUM_FIELDS-1:0] lane_ok;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_lane
        logic [BYTE_W-1:0] cur_b;
        logic [BYTE_W-1:0] alm_b;
        logic              wild;
        assign cur_b      = cur_bytes[g*BYTE_W +: BYTE_W];
        assign alm_b      = alm_bytes[g*BYTE_W +: BYTE_W];
        assign wild       = &alm_b[BYTE_W-1 -: 2];
        assign lane_ok[g] = wild || (alm_b == cur_b);
    end

    assign hit = &lane_ok;
endmodule

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
    import rtc_irq_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] q
);
    logic                 freeze_q;
    logic [CB_SQW_EN-1:0] misc_q;
    logic                 per_en_q, alm_en_q, upd_en_q, sqw_en_q;

    always_ff @(posedge clk) begin
        if (we) begin
            freeze_q <= wdata[CB_FREEZE];
            misc_q   <= wdata[CB_SQW_EN-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_en_q <= 1'b0;
            alm_en_q <= 1'b0;
            upd_en_q <= 1'b0;
            sqw_en_q <= 1'b0;
        end else if (we) begin
            per_en_q <= wdata[CB_PER_EN];
            alm_en_q <= wdata[CB_ALM_EN];
            upd_en_q <= wdata[CB_UPD_EN] && !wdata[CB_FREEZE];
            sqw_en_q <= wdata[CB_SQW_EN];
        end
    end

    always_comb begin
        q            = '0;
        q[CB_FREEZE] = freeze_q;
        q[CB_PER_EN] = per_en_q;
        q[CB_ALM_EN] = alm_en_q;
        q[CB_UPD_EN] = upd_en_q;
        q[CB_SQW_EN] = sqw_en_q;
        q[CB_SQW_EN-1:0] = misc_q;
    end
endmodule

// File: rtl/rtc_flag_unit.sv
module rtc_flag_unit
    import rtc_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  flag_vec_t ev,
    input  flag_vec_t en,
    input  logic      rd,
    output flag_vec_t flags,
    output logic      req
);
    flag_state_e state_q, state_d;
    flag_vec_t   flags_q, flags_d;
    flag_vec_t   pend_q, pend_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            flags_q <= '0;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            flags_q <= flags_d;
            pend_q  <= pend_d;
        end
    end

    always_comb begin
        state_d = state_q;
        flags_d = flags_q;
        pend_d  = pend_q;
        unique case (state_q)
            ST_RUN: begin
                if (rd) begin
                    flags_d = '0;
                    pend_d  = ev;
                    state_d = ST_DRAIN;
                end else begin
                    flags_d = flags_q | ev;
                end
            end
            ST_DRAIN: begin
                if (rd) begin
                    flags_d = '0;
                    pend_d  = pend_q | ev;
                end else begin
                    flags_d = flags_q | pend_q | ev;
                    pend_d  = '0;
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    assign flags = flags_q;
    assign req   = |(flags_q & en);
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
    import rtc_irq_pkg::*;
#(
    parameter int BYTE_W     = rtc_irq_pkg::BYTE_W,
    parameter int NUM_FIELDS = rtc_irq_pkg::NUM_FIELDS,
    localparam int BUS_W     = BYTE_W * NUM_FIELDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              per_tick,
    input  logic              upd_done,
    input  logic [BUS_W-1:0]  time_bytes,
    input  logic [BUS_W-1:0]  alarm_bytes,
    input  logic              stat_rd,
    input  logic              ctrl_we,
    input  logic [BYTE_W-1:0] ctrl_wdata,
    output logic [BYTE_W-1:0] status,
    output logic [BYTE_W-1:0] ctrl,
    output logic              irq_n
);
    logic      alarm_hit;
    flag_vec_t ev, en, flags;
    logic      req;

    rtc_alarm_match #(.BYTE_W(BYTE_W), .NUM_FIELDS(NUM_FIELDS)) u_match (
        .cur_bytes (time_bytes),
        .alm_bytes (alarm_bytes),
        .hit       (alarm_hit)
    );

    rtc_ctrl_reg #(.BYTE_W(BYTE_W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctrl_we),
        .wdata (ctrl_wdata),
        .q     (ctrl)
    );

    always_comb begin
        ev.per = per_tick;
        ev.alm = upd_done && alarm_hit;
        ev.upd = upd_done && !ctrl[CB_FREEZE];
        en.per = ctrl[CB_PER_EN];
        en.alm = ctrl[CB_ALM_EN];
        en.upd = ctrl[CB_UPD_EN];
    end

    rtc_flag_unit u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .ev    (ev),
        .en    (en),
        .rd    (stat_rd),
        .flags (flags),
        .req   (req)
    );

    always_comb begin
        status         = '0;
        status[SB_REQ] = req;
        status[SB_PER] = flags.per;
        status[SB_ALM] = flags.alm;
        status[SB_UPD] = flags.upd;
    end

    assign irq_n = !req;
endmodule

// File: rtl/rtc_irq_ctrl_chk.sv
module rtc_irq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       per_tick,
    input logic       stat_rd,
    input logic       ctrl_we,
    input logic [7:0] ctrl_wdata,
    input logic [7:0] status,
    input logic [7:0] ctrl,
    input logic       irq_n
);
    AST_LOW_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        status[3:0] == 4'h0); // R1

    AST_IRQ_FROM_PORTS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n == !((status[6] && ctrl[6]) || (status[5] && ctrl[5]) || (status[4] && ctrl[4]))); // R3

    AST_REQ_BIT_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        status[7] == !irq_n); // R3

    AST_TICK_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (per_tick && !stat_rd) |=> status[6]); // R4

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status[6] && !stat_rd) |=> status[6]); // R4

    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> (status == 8'h00)); // R5

    AST_HELD_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && per_tick) ##1 !stat_rd |=> status[6]); // R6

    AST_FREEZE_DROPS_UIE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && ctrl_wdata[7]) |=> !ctrl[4]); // R9

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |-> (irq_n && status == 8'h00 && ctrl[6:3] == 4'h0)); // R10
endmodule

bind rtc_irq_ctrl rtc_irq_ctrl_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .per_tick   (per_tick),
    .stat_rd    (stat_rd),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_wdata),
    .status     (status),
    .ctrl       (ctrl),
    .irq_n      (irq_n)
);

// File: tb/test_rtc_irq_ctrl.sv
`timescale 1ns/1ps
module test_rtc_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        per_tick = 1'b0;
    logic        upd_done = 1'b0;
    logic [23:0] time_bytes = '0;
    logic [23:0] alarm_bytes = '0;
    logic        stat_rd = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [7:0]  ctrl_wdata = '0;
    logic [7:0]  status;
    logic [7:0]  ctrl;
    logic        irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string      tag;
        logic [7:0] st;
        logic [7:0] cr;
        logic       irq;
    } exp_t;

    exp_t exp_q[$];
    event chk_ev;

    always #10 clk = ~clk;

    rtc_irq_ctrl i_rtc_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .per_tick(per_tick), .upd_done(upd_done),
        .time_bytes(time_bytes), .alarm_bytes(alarm_bytes), .stat_rd(stat_rd),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .status(status), .ctrl(ctrl), .irq_n(irq_n)
    );

    task automatic drain();
        while (exp_q.size() > 0) begin
            exp_t e = exp_q.pop_front();
            checks++;
            if (status !== e.st || ctrl !== e.cr || irq_n !== e.irq) begin
                errors++;
                $display("FAIL %s: status=%h ctrl=%h irq_n=%b expected status=%h ctrl=%h irq_n=%b",
                         e.tag, status, ctrl, irq_n, e.st, e.cr, e.irq);
            end
        end
    endtask

    initial begin : monitor
        forever begin
            @(chk_ev);
            drain();
        end
    end

    task automatic expect_now(string tag, logic [7:0] st, logic [7:0] cr, logic irq);
        exp_t e;
        e.tag = tag; e.st = st; e.cr = cr; e.irq = irq;
        exp_q.push_back(e);
        -> chk_ev;
        #1;
    endtask

    task automatic step();
        @(posedge clk);
        #5;
    endtask

    task automatic wr_ctrl(logic [7:0] d);
        ctrl_we = 1'b1; ctrl_wdata = d;
        step();
        ctrl_we = 1'b0;
    endtask

    task automatic pulse_tick();
        per_tick = 1'b1; step(); per_tick = 1'b0;
    endtask

    task automatic pulse_upd();
        upd_done = 1'b1; step(); upd_done = 1'b0;
    endtask

    task automatic rd_status();
        stat_rd = 1'b1; step(); stat_rd = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run hung, expected completion");
            drain();
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        step();
        // R10 R2: enables held at 0 in reset, freeze and low bits stored
        wr_ctrl(8'h7D);
        expect_now("R10 reset state", 8'h00, 8'h05, 1'b1);
        rst_n = 1'b1;
        step();

        // R4: tick sets flag with enable off
        pulse_tick();
        expect_now("R4 flag without enable", 8'h40, 8'h05, 1'b1);
        // R3: enable with flag pending asserts at once
        wr_ctrl(8'h45);
        expect_now("R3 late enable", 8'hC0, 8'h45, 1'b0);
        // R5: value stable during read, cleared after
        stat_rd = 1'b1;
        expect_now("R5 read value", 8'hC0, 8'h45, 1'b0);
        step(); stat_rd = 1'b0;
        expect_now("R5 cleared after read", 8'h00, 8'h45, 1'b1);

        // R6: tick coincident with read held over
        pulse_tick();
        stat_rd = 1'b1; per_tick = 1'b1;
        step(); stat_rd = 1'b0; per_tick = 1'b0;
        expect_now("R6 held hidden", 8'h00, 8'h45, 1'b1);
        step();
        expect_now("R6 held merged", 8'hC0, 8'h45, 1'b0);
        rd_status();

        // R7 R8: exact alarm match with alarm enable
        wr_ctrl(8'h25);
        time_bytes  = 24'h12_30_45;
        alarm_bytes = 24'h12_30_45;
        step();
        expect_now("R7 no alarm without update", 8'h00, 8'h25, 1'b1);
        pulse_upd();
        expect_now("R7 exact match", 8'hB0, 8'h25, 1'b0);
        rd_status();

        alarm_bytes = 24'h12_30_46;
        pulse_upd();
        expect_now("R7 mismatch", 8'h10, 8'h25, 1'b1);
        rd_status();

        alarm_bytes = 24'hE5_FF_C0;
        time_bytes  = 24'h07_11_23;
        pulse_upd();
        expect_now("R7 all wildcards", 8'hB0, 8'h25, 1'b0);
        rd_status();

        alarm_bytes = 24'h07_12_C0;
        pulse_upd();
        expect_now("R7 partial wildcard miss", 8'h10, 8'h25, 1'b1);
        rd_status();

        alarm_bytes = 24'h07_11_80;
        pulse_upd();
        expect_now("R7 top bit alone not wildcard", 8'h10, 8'h25, 1'b1);
        rd_status();

        // R9 R8: freeze write forces update enable off and blocks update flag
        alarm_bytes = 24'h00_00_00;
        wr_ctrl(8'h90);
        expect_now("R9 freeze clears uie", 8'h00, 8'h80, 1'b1);
        pulse_upd();
        expect_now("R8 frozen no update flag", 8'h00, 8'h80, 1'b1);
        wr_ctrl(8'h10);
        pulse_upd();
        expect_now("R8 update flag with enable", 8'h90, 8'h10, 1'b0);
        rd_status();

        // R10: reset clears flags and enables, keeps freeze and low bits
        wr_ctrl(8'hFB);
        pulse_tick();
        expect_now("R3 R9 before reset", 8'hC0, 8'hEB, 1'b0);
        rst_n = 1'b0;
        #2;
        expect_now("R10 reset applied", 8'h00, 8'h83, 1'b1);
        step();
        rst_n = 1'b1;
        step();
        expect_now("R10 after release", 8'h00, 8'h83, 1'b1);

        drain();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule